// File: doc/BRIEF.md
# Packed Decimal Digit Adder

This block adds two packed decimal operands, four bits per decimal digit, together with a single carry bit. It is purely combinational. Each digit position runs the two operand digits and the incoming carry through a four-bit binary adder. The block then inspects that intermediate value. When the value has gone past nine, a second four-bit adder adds six to it, which produces a valid decimal digit and a decimal carry.

The decimal carry of each position feeds the carry input of the next more significant position. The lowest nibble holds the least significant digit. The parameter `DIGITS` sets how many positions are chained, and the default is one.

A separate check watches every operand nibble. It raises a flag when any nibble holds a code from ten to fifteen. While the flag is high, the sum outputs carry no meaning.

Top module: `bcd_ripple_adder`

## Requirements
- R1: For one digit with legal operands, the sum digit equals (a + b + cin) modulo 10.
- R2: For one digit with legal operands, the carry-out is 1 exactly when a + b + cin is 10 or more.
- R3: When the intermediate binary sum is at most 9 with no binary carry, the sum digit equals the intermediate sum and the carry-out is 0.
- R4: When the intermediate binary sum is between 10 and 15 with no binary carry, six is added to it (keeping four bits) and the carry-out is 1.
- R5: When the first adder produces a binary carry (raw totals 16 to 19), six is added to the intermediate sum and the carry-out is 1.
- R6: With several digits, digit i occupies bits 4i+3..4i, and each digit's carry-out drives the carry-in of digit i+1. The outputs {cout, sum} then equal the decimal value of A + B + cin.
- R7: The invalid flag is 1 exactly when some nibble of A or of B holds a value from 10 to 15.
- R8: Every sum digit is in the range 0 to 9 whenever all operand nibbles are legal.
- R9: The carry-in enters digit 0 only. With zero operands and carry-in 1, the result is 1 in digit 0 and 0 in every other digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*DIGITS | First packed decimal operand, digit 0 in the low nibble |
| b_i | input | 4*DIGITS | Second packed decimal operand |
| cin_i | input | 1 | Carry into digit 0 |
| sum_o | output | 4*DIGITS | Packed decimal sum |
| cout_o | output | 1 | Decimal carry out of the top digit |
| bad_operand_o | output | 1 | High when any operand nibble exceeds 9 |

## Verification
Inside each digit slice, the assertions relate the first adder's output to the corrected digit and the carry for every input the slice receives. They cover the pass-through, over-nine and binary-carry cases, and the rule that a legal input gives a legal digit whose value matches the arithmetic total. Only the bench's scenarios can show that the slices are chained in the right order and that the carry-in reaches the lowest digit alone. The same holds for the invalid flag, which is driven by a separate path. The bench checks a full sweep of legal single-digit inputs, long carry ripples across a three-digit build, and illegal nibbles in several positions.

// File: rtl/bcd_add_pkg.sv
`timescale 1ns/1ps
package bcd_add_pkg;
    localparam int NIB_W     = 4;
    localparam int MAX_DIGIT = 9;
    localparam int CORR      = 6;

    typedef logic [NIB_W-1:0] nib_t;

    function automatic logic nib_is_digit(input nib_t n);
        return n <= nib_t'(MAX_DIGIT);
    endfunction
endpackage

// File: rtl/nib_adder4.sv
`timescale 1ns/1ps
module nib_adder4
    import bcd_add_pkg::*;
(
    input  nib_t x_i,
    input  nib_t y_i,
    input  logic ci_i,
    output nib_t s_o,
    output logic co_o
);
    localparam int SUM_W = NIB_W + 1;

    logic [SUM_W-1:0] full;

    assign full = SUM_W'(x_i) + SUM_W'(y_i) + SUM_W'(ci_i);
    assign s_o  = full[NIB_W-1:0];
    assign co_o = full[NIB_W];
endmodule

// File: rtl/digit_valid_check.sv
`timescale 1ns/1ps
module digit_valid_check
    import bcd_add_pkg::*;
(
    input  nib_t a_i,
    input  nib_t b_i,
    output logic bad_o
);
    assign bad_o = !nib_is_digit(a_i) || !nib_is_digit(b_i);
endmodule

// File: rtl/bcd_digit_slice.sv
`timescale 1ns/1ps
module bcd_digit_slice
    import bcd_add_pkg::*;
(
    input  nib_t a_i,
    input  nib_t b_i,
    input  logic c_i,
    output nib_t s_o,
    output logic c_o
);
    nib_t raw;
    logic raw_c;
    nib_t fix;
    logic fix_c;
    logic over9;

    // first stage: plain binary sum of the two digits and the carry
    nib_adder4 u_raw (
        .x_i (a_i),
        .y_i (b_i),
        .ci_i(c_i),
        .s_o (raw),
        .co_o(raw_c)
    );

    // 10..15 seen through the top bit and either middle bit
    assign over9 = raw[3] & (raw[2] | raw[1]);
    assign c_o   = raw_c | over9;
    assign fix   = c_o ? nib_t'(CORR) : '0;

    // second stage: decimal correction, its carry is not propagated
    nib_adder4 u_fix (
        .x_i (raw),
        .y_i (fix),
        .ci_i(1'b0),
        .s_o (s_o),
        .co_o(fix_c)
    );

    always_comb begin
        int total;
        total = int'(a_i) + int'(b_i) + int'(c_i);
        if (!raw_c && raw <= nib_t'(MAX_DIGIT))
            a_r3_pass_through: assert (!c_o && s_o == raw && !fix_c);
        if (!raw_c && raw > nib_t'(MAX_DIGIT))
            a_r4_over_nine: assert (c_o && s_o == nib_t'(raw - 4'd10));
        if (raw_c)
            a_r5_binary_carry: assert (c_o && s_o == nib_t'(raw + 4'd6));
        if (nib_is_digit(a_i) && nib_is_digit(b_i)) begin
            a_r8_digit_legal: assert (s_o <= nib_t'(MAX_DIGIT));
            a_r1_digit_value: assert (total == (c_o ? 10 : 0) + int'(s_o));
        end
    end
endmodule

// File: rtl/bcd_ripple_adder.sv
`timescale 1ns/1ps
module bcd_ripple_adder
    import bcd_add_pkg::*;
#(
    parameter int DIGITS = 1
) (
    input  logic [4*DIGITS-1:0] a_i,
    input  logic [4*DIGITS-1:0] b_i,
    input  logic                cin_i,
    output logic [4*DIGITS-1:0] sum_o,
    output logic                cout_o,
    output logic                bad_operand_o
);
    localparam int W = NIB_W * DIGITS;

    logic [DIGITS:0]   chain;
    logic [DIGITS-1:0] bad;

    assign chain[0] = cin_i;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        bcd_digit_slice u_slice (
            .a_i(a_i[d*NIB_W +: NIB_W]),
            .b_i(b_i[d*NIB_W +: NIB_W]),
            .c_i(chain[d]),
            .s_o(sum_o[d*NIB_W +: NIB_W]),
            .c_o(chain[d+1])
        );
        digit_valid_check u_chk (
            .a_i  (a_i[d*NIB_W +: NIB_W]),
            .b_i  (b_i[d*NIB_W +: NIB_W]),
            .bad_o(bad[d])
        );
    end

    assign cout_o        = chain[DIGITS];
    assign bad_operand_o = |bad;

    always_comb begin
        if (!bad_operand_o)
            a_r6_top_carry_bound: assert (!(cout_o && sum_o == W'(0) && a_i == W'(0) && b_i == W'(0)));
    end
endmodule

// File: tb/bcd_ripple_adder_test.sv
`timescale 1ns/1ps
module bcd_ripple_adder_test;
    localparam int WD = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] a1, b1, s1;
    logic c1, co1, bad1;
    logic [4*WD-1:0] aw, bw, sw;
    logic cw, cow, badw;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    bcd_ripple_adder #(.DIGITS(1)) uut (
        .a_i(a1), .b_i(b1), .cin_i(c1),
        .sum_o(s1), .cout_o(co1), .bad_operand_o(bad1)
    );

    bcd_ripple_adder #(.DIGITS(WD)) uut_wide (
        .a_i(aw), .b_i(bw), .cin_i(cw),
        .sum_o(sw), .cout_o(cow), .bad_operand_o(badw)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int to_dec(input logic [4*WD-1:0] v);
        int r = 0;
        for (int i = WD - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
        return r;
    endfunction

    function automatic logic [4*WD-1:0] to_bcd(input int v);
        logic [4*WD-1:0] r = '0;
        int t = v;
        for (int i = 0; i < WD; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic run_one(input int a, input int b, input int c);
        int total;
        @(negedge clk);
        a1 = 4'(a); b1 = 4'(b); c1 = c[0];
        @(posedge clk); #1;
        total = a + b + c;
        check("R1 digit", s1, total % 10);
        check("R2 carry", co1, total >= 10);
        check("R8 range", s1 <= 9, 1);
        check("R7 flag legal", bad1, 0);
        if (total <= 9)       check("R3 pass-through", {co1, s1}, total);
        else if (total <= 15) check("R4 over-nine", {co1, s1}, 16 + total - 10);
        else                  check("R5 binary carry", {co1, s1}, 16 + total - 10);
    endtask

    task automatic run_wide(input int a, input int b, input int c, input string req);
        int total;
        @(negedge clk);
        aw = to_bcd(a); bw = to_bcd(b); cw = c[0];
        @(posedge clk); #1;
        total = a + b + c;
        check(req, to_dec(sw), total % 1000);
        check(req, cow, total >= 1000);
        check("R7 flag legal wide", badw, 0);
    endtask

    initial begin
        a1 = '0; b1 = '0; c1 = 1'b0;
        aw = '0; bw = '0; cw = 1'b0;
        @(posedge clk); #1;
        check("R3 idle zero", {co1, s1}, 0);
        check("R6 idle zero", {cow, sw}, 0);

        for (int a = 0; a <= 9; a++)
            for (int b = 0; b <= 9; b++)
                for (int c = 0; c <= 1; c++)
                    run_one(a, b, c);

        run_wide(999, 1, 0, "R6 full ripple");
        run_wide(999, 999, 1, "R6 max");
        run_wide(456, 789, 0, "R6 mixed");
        run_wide(95, 5, 0, "R6 two-step ripple");
        run_wide(0, 0, 1, "R9 cin to digit0");
        run_wide(123, 654, 0, "R6 no carry");

        // invalid nibble codes 10..15 in each operand and position
        for (int v = 10; v <= 15; v++) begin
            @(negedge clk);
            a1 = 4'(v); b1 = 4'd3; c1 = 1'b0;
            @(posedge clk); #1;
            check("R7 bad a", bad1, 1);
            @(negedge clk);
            a1 = 4'd2; b1 = 4'(v);
            @(posedge clk); #1;
            check("R7 bad b", bad1, 1);
        end
        for (int p = 0; p < WD; p++) begin
            @(negedge clk);
            aw = to_bcd(111); bw = to_bcd(222); cw = 1'b0;
            bw[p*4 +: 4] = 4'hC;
            @(posedge clk); #1;
            check("R7 bad wide nibble", badw, 1);
        end
        @(negedge clk);
        a1 = 4'd9; b1 = 4'd9; c1 = 1'b1;
        @(posedge clk); #1;
        check("R7 legal edge", bad1, 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule